// File: doc/BRIEF.md
# Iterative Carry-Rippling Adder

This block adds or subtracts two words without a carry chain. It keeps the running sum in an accumulator register and the pending carries in a second register. On every clock it replaces the accumulator with the exclusive OR of the accumulator and the pending carries. The carries that this step produces move up one bit and become the next addend. The operation ends when no carries are left. The latency therefore depends on the operands, from zero extra cycles up to one cycle per bit.

A client pulses `start` with the two operands and the operation select, then waits for `busy` to fall. The first partial step happens in the same clock that captures the operands. For subtraction the subtrahend is inverted and a 1 is placed in bit 0 of the initial carry word. A carry that leaves the top bit sets a sticky flag, which is cleared when the next operation is accepted. The result and the flag are valid whenever `busy` is low.

Top module: `iadd_ripple`

## Requirements
- R1: After reset, `result` is 0, `busy` is 0 and `carry_out` is 0.
- R2: When `start` is high and `busy` is low, the operands are taken on that clock edge, and `carry_out` is cleared apart from any carry leaving the top bit in that first step.
- R3: With `sub_mode` = 0, once `busy` is low again `result` equals (`op_a` + `op_b`) mod 2^WIDTH.
- R4: With `sub_mode` = 1, once `busy` is low again `result` equals (`op_a` - `op_b`) mod 2^WIDTH. `carry_out` is 1 exactly when `op_a` >= `op_b` as unsigned numbers, so 1 means no borrow.
- R5: With `sub_mode` = 0, `carry_out` is 1 exactly when `op_a` + `op_b` >= 2^WIDTH.
- R6: `busy` is high exactly while pending carries remain. It is high for at most WIDTH cycles after the load edge. 0 - 0 takes exactly WIDTH busy cycles, and (2^WIDTH-1) + 1 takes exactly WIDTH-1.
- R7: An addition with `op_b` = 0 leaves `busy` low in the cycle after the load, and `result` then equals `op_a`.
- R8: A `start` pulse while `busy` is high is ignored. The running operation ends with its own result.
- R9: While `busy` is low and `start` is low, `result` and `carry_out` hold their values whatever the operand inputs do.
- R10: During every step the sum of the accumulator, the pending carries, and `carry_out` weighted by 2^WIDTH stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; taken only while idle |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| op_a | input | WIDTH | First operand (minuend when subtracting) |
| op_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| result | output | WIDTH | Accumulator; final value once busy is low |
| busy | output | 1 | Pending carries remain |
| carry_out | output | 1 | Sticky carry out of the top bit |

## Verification
The bench targets the longest carry walks: 0 - 0 and all-ones + 1 must take exactly WIDTH and WIDTH-1 busy cycles. A design that dropped the injected bit-0 carry, or shifted the carries wrongly, would end early or late with a wrong result. A zero addend must leave `busy` low at once; a design that counted steps instead of watching the carry word would stay busy. A second `start` during an operation must not disturb it; a design that reloaded would return the second sum. Random add and subtract pairs are checked against computed sums, borrow flags and the WIDTH-cycle bound. A flag that was not sticky, or not cleared at load, would show up in `carry_out`.

// File: rtl/iadd_pkg.sv
package iadd_pkg;
  localparam int unsigned IADD_WIDTH = 16;
endpackage

// File: rtl/iadd_operand.sv
module iadd_operand #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             sub_mode,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] addend,
  output logic             inject
);
  // subtract: add the one's complement plus a 1 in bit 0
  always_comb begin
    addend = sub_mode ? ~op_b : op_b;
    inject = sub_mode;
  end
endmodule

// File: rtl/iadd_step.sv
module iadd_step #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  input  logic             inject,
  output logic [WIDTH-1:0] part_sum,
  output logic [WIDTH-1:0] carries,
  output logic             top_carry
);
  logic [WIDTH-1:0] gen;

  always_comb begin
    gen       = lhs & rhs;
    part_sum  = lhs ^ rhs;
    carries   = {gen[WIDTH-2:0], inject};
    top_carry = gen[WIDTH-1];
  end
endmodule

// File: rtl/iadd_ripple.sv
module iadd_ripple
  import iadd_pkg::*;
#(
  parameter int unsigned WIDTH = IADD_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sub_mode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] result,
  output logic             busy,
  output logic             carry_out
);
  localparam int unsigned LW = $clog2(WIDTH + 2);
  localparam int unsigned TW = WIDTH + 2;

  logic [WIDTH-1:0] acc_q, acc_d;
  logic [WIDTH-1:0] car_q, car_d;
  logic             cout_q, cout_d;
  logic             accept, step_en;

  logic [WIDTH-1:0] cond_b;
  logic             cond_inj;
  logic [WIDTH-1:0] s_lhs, s_rhs, s_sum, s_car;
  logic             s_inj, s_top;

  iadd_operand #(.WIDTH(WIDTH)) u_operand (
    .sub_mode (sub_mode),
    .op_b     (op_b),
    .addend   (cond_b),
    .inject   (cond_inj)
  );

  iadd_step #(.WIDTH(WIDTH)) u_step (
    .lhs       (s_lhs),
    .rhs       (s_rhs),
    .inject    (s_inj),
    .part_sum  (s_sum),
    .carries   (s_car),
    .top_carry (s_top)
  );

  always_comb begin
    accept  = start && (car_q == '0);
    step_en = accept || (car_q != '0);
    s_lhs   = accept ? op_a   : acc_q;
    s_rhs   = accept ? cond_b : car_q;
    s_inj   = accept && cond_inj;
    acc_d   = acc_q;
    car_d   = car_q;
    cout_d  = cout_q;
    if (step_en) begin
      acc_d  = s_sum;
      car_d  = s_car;
      cout_d = accept ? s_top : (cout_q | s_top);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      car_q  <= '0;
      cout_q <= 1'b0;
    end else if (step_en) begin
      acc_q  <= acc_d;
      car_q  <= car_d;
      cout_q <= cout_d;
    end
  end

  assign result    = acc_q;
  assign busy      = (car_q != '0);
  assign carry_out = cout_q;

  // ---------------- checks ----------------
  logic [LW-1:0] lat_q;
  logic [TW-1:0] total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       lat_q <= '0;
    else if (accept)                  lat_q <= '0;
    else if (busy && lat_q != '1)     lat_q <= lat_q + 1'b1;
  end

  always_comb total = TW'(acc_q) + TW'(car_q) + (TW'(cout_q) << WIDTH);

  AST_LAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q <= LW'(WIDTH)); // R6
  AST_SUM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> total == $past(total)); // R10
  AST_BIT0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !car_q[0]); // R6
  AST_COUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && carry_out) |=> carry_out); // R2
  AST_ZERO_ADDEND: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !sub_mode && op_b == '0) |=> (!busy && result == $past(op_a))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(result) && $stable(carry_out) && !busy)); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> total == $past(total)); // R8
endmodule

// File: tb/iadd_ripple_test.sv
module iadd_ripple_test;
  localparam int unsigned W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         sub_mode = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [W-1:0] result;
  logic         busy;
  logic         carry_out;

  int n_tests = 0;
  int n_fail  = 0;

  iadd_ripple #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sub_mode(sub_mode),
    .op_a(op_a), .op_b(op_b), .result(result), .busy(busy), .carry_out(carry_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W:0] ref_op(input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
    if (s) ref_op = {1'b0, a} + {1'b0, ~b} + 1'b1;
    else   ref_op = {1'b0, a} + {1'b0, b};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_le(input string req, input int act, input int lim);
    n_tests++;
    if (act > lim) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected<=%0d", req, act, lim);
    end
  endtask

  // one operation; returns busy cycles seen after the load edge
  task automatic run_op(input logic s, input logic [W-1:0] a, input logic [W-1:0] b,
                        output int cyc);
    @(negedge clk);
    start = 1'b1; sub_mode = s; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 4*W) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic check_op(input string req, input logic s, input logic [W-1:0] a,
                          input logic [W-1:0] b);
    logic [W:0] e;
    int cyc;
    e = ref_op(s, a, b);
    run_op(s, a, b, cyc);
    check(req, 32'(result), 32'(e[W-1:0]));
    check(s ? "R4 flag" : "R5 flag", 32'(carry_out), 32'(e[W]));
    check_le("R6 latency", cyc, W);
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    logic [W-1:0] held;
    void'($urandom(32'd2718));
    #(2*CLK_PERIOD + 3ns);
    // R1 reset state
    check("R1 result", 32'(result), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 carry_out", 32'(carry_out), 0);
    rst_n = 1'b1;

    // R6 exact worst cases
    run_op(1'b1, 16'h0000, 16'h0000, cyc);
    check("R6 0-0 cycles", cyc, W);
    check("R4 0-0 result", 32'(result), 0);
    check("R4 0-0 flag", 32'(carry_out), 1);
    run_op(1'b0, 16'hFFFF, 16'h0001, cyc);
    check("R6 ones+1 cycles", cyc, W-1);
    check("R5 ones+1 flag", 32'(carry_out), 1);
    check("R3 ones+1 result", 32'(result), 0);

    // R7 zero addend
    run_op(1'b0, 16'hBEEF, 16'h0000, cyc);
    check("R7 cycles", cyc, 0);
    check("R7 result", 32'(result), 32'h0000BEEF);
    check("R2 flag cleared", 32'(carry_out), 0);

    // R4 borrow
    check_op("R4 small-big", 1'b1, 16'h0003, 16'h0005);
    check_op("R4 equal", 1'b1, 16'h1234, 16'h1234);
    check_op("R3 max+max", 1'b0, 16'hFFFF, 16'hFFFF);

    // R8 start while busy ignored
    @(negedge clk);
    start = 1'b1; sub_mode = 1'b1; op_a = 16'h0000; op_b = 16'h0000;
    @(negedge clk);
    op_a = 16'h0111; op_b = 16'h0222; sub_mode = 1'b0;
    check("R8 busy before restart", 32'(busy), 1);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 4*W) begin cyc++; @(negedge clk); end
    check("R8 result", 32'(result), 0);
    check("R8 flag", 32'(carry_out), 1);

    // R9 hold while idle
    held = result;
    for (int i = 0; i < 5; i++) begin
      op_a = 16'(($urandom)); op_b = 16'(($urandom)); sub_mode = i[0];
      @(negedge clk);
    end
    check("R9 result held", 32'(result), 32'(held));
    check("R9 flag held", 32'(carry_out), 1);
    check("R9 idle", 32'(busy), 0);

    // R3/R4/R5 random
    for (int i = 0; i < 300; i++) begin
      check_op((i % 2) ? "R4 random" : "R3 random", i[0], 16'($urandom), 16'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule